// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by reading two levels of translation entries from memory. A page directory, located through a base address input, is indexed by the top ten bits of the linear address. The selected directory entry points to a page table, and the next ten bits index that table. The final entry supplies a 4 KB frame, and the low twelve bits of the linear address are carried through unchanged as the offset within that frame.

On the way, the walker checks the present bit at both levels. For a user-mode access it also checks the user/supervisor and read/write bits of both entries, and the more restrictive of the two levels decides. Supervisor accesses ignore those two bits. When an access is allowed, the walker writes entries back to record the accessed bit at both levels and the dirty bit in the table entry on a write. An entry is written only if one of its bits actually changes.

The block is used as the miss path behind a translation front end. A requester presents the linear address, the access kind and a start strobe. It then waits for a one-cycle completion pulse that comes with either a physical address or a fault code. The memory side is a single-outstanding request/acknowledge port.

Top module: `pageWalker`

## Requirements
- R1: On an accepted start, the first memory access is a read at `dirBase + linAddr[31:22]*4`.
- R2: If the directory entry has its present bit (bit 0) set, the second access is a read at `{pde[31:12],12'h000} + linAddr[21:12]*4`.
- R3: A successful walk raises `done` for exactly one cycle with `fault`=0, `faultCode`=2'b00 and `physAddr` = `{pte[31:12], linAddr[11:0]}`.
- R4: A clear present bit at either level ends the walk with `fault`=1 and `faultCode`=2'b01. A missing directory entry causes no table read, and a not-present fault writes nothing back.
- R5: A supervisor access (`isUser`=0) to present entries never faults, whatever the values of the user bit (bit 2) and writable bit (bit 1).
- R6: A user access faults with `faultCode`=2'b10 and no write-back when either entry has its user bit clear, or when it is a write and either entry has its writable bit clear. `physAddr` is 0 on any fault.
- R7: After an allowed access, the accessed bit (bit 5) is set in the directory entry, and bits 5 and, on a write, 6 (dirty) are set in the table entry. All other entry bits are kept. An entry is written only when its value changes.
- R8: A memory request holds its address, write flag and write data stable until it is acknowledged.
- R9: After reset, `done`, `fault`, `faultCode`, `physAddr` and `memReq` are all 0. A start that arrives while a walk is in progress is ignored.
- R10: When both entries need a write-back, the directory entry is written before the table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| linAddr | input | 32 | Linear address to translate |
| isWrite | input | 1 | Access is a write |
| isUser | input | 1 | Access comes from user mode |
| dirBase | input | 32 | Physical base address of the page directory |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Request address |
| memWData | output | 32 | Write data |
| memAck | input | 1 | Request completed (read data valid this cycle) |
| memRData | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault |
| faultCode | output | 2 | 00 none, 01 not present, 10 protection |
| physAddr | output | 32 | Translated physical address |

## Verification
The bench sweeps every combination of present, user and writable bits at both levels. It crosses these with user or supervisor mode, read or write, the starting accessed and dirty bits, and memory latencies of zero to two wait cycles. This exposes a walker that takes permissions from only one level, since it would pass user accesses that the other entry forbids. It also exposes one that applies user rules to supervisor accesses, since that design would fault on read-only or supervisor-only pages. The final memory contents and the order of the writes are compared against the expected values. A design that writes back unchanged entries, forgets the dirty bit, disturbs the available or cache-control bits, or writes anything on a fault therefore shows up. Some walks receive a second start in mid-walk, which catches a walker that restarts or issues extra reads.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int ADDR_W = 32;
  localparam int BIT_P  = 0;
  localparam int BIT_RW = 1;
  localparam int BIT_US = 2;
  localparam int BIT_A  = 5;
  localparam int BIT_D  = 6;

  typedef enum logic [1:0] {
    FC_NONE = 2'b00,
    FC_NP   = 2'b01,
    FC_PROT = 2'b10
  } faultCode_e;

  typedef enum logic {
    SEL_DIR = 1'b0,
    SEL_TBL = 1'b1
  } addrSel_e;

  typedef struct packed {
    logic       ldInputs;
    logic       ldPde;
    logic       ldPte;
    addrSel_e   addrSel;
    logic       finish;
    faultCode_e code;
  } pwStrobes_t;

  typedef struct packed {
    logic pdePresent;
    logic ptePresent;
    logic permOk;
    logic pdeNeedWb;
    logic pteNeedWb;
  } pwFlags_t;
endpackage

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       memAck,
  input  pwFlags_t   flags,
  output pwStrobes_t strb,
  output logic       memReq,
  output logic       memWe,
  output logic       done
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DIR, ST_CHK_DIR, ST_RD_TBL, ST_CHK_TBL,
    ST_WB_DIR, ST_WB_TBL, ST_FIN
  } state_e;

  state_e     state, stateNext;
  faultCode_e faultQ, faultNext;

  always_comb begin
    stateNext     = state;
    faultNext     = faultQ;
    strb          = '0;
    strb.addrSel  = SEL_DIR;
    strb.code     = faultQ;
    memReq        = 1'b0;
    memWe         = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.ldInputs = 1'b1;
          faultNext     = FC_NONE;
          stateNext     = ST_RD_DIR;
        end
      end
      ST_RD_DIR: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.ldPde = 1'b1;
          stateNext  = ST_CHK_DIR;
        end
      end
      ST_CHK_DIR: begin
        if (!flags.pdePresent) begin
          faultNext = FC_NP;
          stateNext = ST_FIN;
        end else begin
          stateNext = ST_RD_TBL;
        end
      end
      ST_RD_TBL: begin
        memReq       = 1'b1;
        strb.addrSel = SEL_TBL;
        if (memAck) begin
          strb.ldPte = 1'b1;
          stateNext  = ST_CHK_TBL;
        end
      end
      ST_CHK_TBL: begin
        if (!flags.ptePresent) begin
          faultNext = FC_NP;
          stateNext = ST_FIN;
        end else if (!flags.permOk) begin
          faultNext = FC_PROT;
          stateNext = ST_FIN;
        end else if (flags.pdeNeedWb) begin
          stateNext = ST_WB_DIR;
        end else if (flags.pteNeedWb) begin
          stateNext = ST_WB_TBL;
        end else begin
          stateNext = ST_FIN;
        end
      end
      ST_WB_DIR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) stateNext = flags.pteNeedWb ? ST_WB_TBL : ST_FIN;
      end
      ST_WB_TBL: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        strb.addrSel = SEL_TBL;
        if (memAck) stateNext = ST_FIN;
      end
      ST_FIN: begin
        strb.finish = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      faultQ <= FC_NONE;
      done   <= 1'b0;
    end else begin
      state  <= stateNext;
      faultQ <= faultNext;
      done   <= (state == ST_FIN);
    end
  end
endmodule

// File: rtl/pw_dpath.sv
module pw_dpath
  import pw_pkg::*;
#(
  parameter int DIR_BITS = 10,
  parameter int TBL_BITS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwStrobes_t        strb,
  input  logic [ADDR_W-1:0] linAddr,
  input  logic              isWrite,
  input  logic              isUser,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic [ADDR_W-1:0] memRData,
  output pwFlags_t          flags,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWData,
  output logic              fault,
  output logic [1:0]        faultCode,
  output logic [ADDR_W-1:0] physAddr
);
  localparam int OFF_BITS = ADDR_W - DIR_BITS - TBL_BITS;
  localparam int FRM_BITS = ADDR_W - OFF_BITS;
  localparam int IDX_PAD  = ADDR_W - 2;

  logic [ADDR_W-1:0] laQ, baseQ, pdeQ, pteQ;
  logic              wrQ, userQ;
  logic [ADDR_W-1:0] dirAddr, tblAddr, pdeNew, pteNew;
  logic [DIR_BITS-1:0] dirIdx;
  logic [TBL_BITS-1:0] tblIdx;
  logic [OFF_BITS-1:0] pageOff;

  assign dirIdx  = laQ[ADDR_W-1 -: DIR_BITS];
  assign tblIdx  = laQ[OFF_BITS +: TBL_BITS];
  assign pageOff = laQ[OFF_BITS-1:0];

  assign dirAddr = baseQ + {IDX_PAD'(dirIdx), 2'b00};
  assign tblAddr = {pdeQ[ADDR_W-1:OFF_BITS], OFF_BITS'(0)} + {IDX_PAD'(tblIdx), 2'b00};

  always_comb begin
    pdeNew = pdeQ;
    pdeNew[BIT_A] = 1'b1;
    pteNew = pteQ;
    pteNew[BIT_A] = 1'b1;
    if (wrQ) pteNew[BIT_D] = 1'b1;
  end

  always_comb begin
    flags.pdePresent = pdeQ[BIT_P];
    flags.ptePresent = pteQ[BIT_P];
    flags.permOk     = !userQ ||
                       (pdeQ[BIT_US] && pteQ[BIT_US] &&
                        (!wrQ || (pdeQ[BIT_RW] && pteQ[BIT_RW])));
    flags.pdeNeedWb  = (pdeNew != pdeQ);
    flags.pteNeedWb  = (pteNew != pteQ);
  end

  assign memAddr  = (strb.addrSel == SEL_TBL) ? tblAddr : dirAddr;
  assign memWData = (strb.addrSel == SEL_TBL) ? pteNew  : pdeNew;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laQ       <= '0;
      baseQ     <= '0;
      wrQ       <= 1'b0;
      userQ     <= 1'b0;
      pdeQ      <= '0;
      pteQ      <= '0;
      fault     <= 1'b0;
      faultCode <= 2'b00;
      physAddr  <= '0;
    end else begin
      if (strb.ldInputs) begin
        laQ   <= linAddr;
        baseQ <= dirBase;
        wrQ   <= isWrite;
        userQ <= isUser;
      end
      if (strb.ldPde) pdeQ <= memRData;
      if (strb.ldPte) pteQ <= memRData;
      if (strb.finish) begin
        fault     <= (strb.code != FC_NONE);
        faultCode <= strb.code;
        physAddr  <= (strb.code == FC_NONE) ?
                     {pteQ[ADDR_W-1 -: FRM_BITS], pageOff} : '0;
      end
    end
  end
endmodule

// File: rtl/pageWalker.sv
module pageWalker
  import pw_pkg::*;
#(
  parameter int DIR_BITS = 10,
  parameter int TBL_BITS = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] linAddr,
  input  logic        isWrite,
  input  logic        isUser,
  input  logic [31:0] dirBase,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWData,
  input  logic        memAck,
  input  logic [31:0] memRData,
  output logic        done,
  output logic        fault,
  output logic [1:0]  faultCode,
  output logic [31:0] physAddr
);
  pwStrobes_t strb;
  pwFlags_t   flags;

  pw_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .memAck (memAck),
    .flags  (flags),
    .strb   (strb),
    .memReq (memReq),
    .memWe  (memWe),
    .done   (done)
  );

  pw_dpath #(
    .DIR_BITS (DIR_BITS),
    .TBL_BITS (TBL_BITS)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .linAddr   (linAddr),
    .isWrite   (isWrite),
    .isUser    (isUser),
    .dirBase   (dirBase),
    .memRData  (memRData),
    .flags     (flags),
    .memAddr   (memAddr),
    .memWData  (memWData),
    .fault     (fault),
    .faultCode (faultCode),
    .physAddr  (physAddr)
  );
endmodule

// File: rtl/pageWalker_chk.sv
module pageWalker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic [31:0] memWData,
  input logic        memAck,
  input logic        done,
  input logic        fault,
  input logic [1:0]  faultCode,
  input logic [31:0] physAddr
);
  // R8: request fields stay put until acknowledged
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWData)));

  // R3: completion is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: the fault flag agrees with the reported code
  p_code_agree_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (fault == (faultCode != 2'b00)));

  // R6: no physical address leaks out on a fault
  p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault) |-> (physAddr == 32'h0));

  // R7: every write-back records the accessed bit
  p_wb_accessed_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> memWData[5]);

  // R9: no memory activity in the completion cycle
  p_idle_at_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

  // R4: code 2'b11 is never produced
  p_code_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    faultCode != 2'b11);
endmodule

bind pageWalker pageWalker_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memReq    (memReq),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .memWData  (memWData),
  .memAck    (memAck),
  .done      (done),
  .fault     (fault),
  .faultCode (faultCode),
  .physAddr  (physAddr)
);

// File: tb/pageWalker_tb.sv
`timescale 1ns/1ps
module pageWalker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] linAddr = '0;
  logic        isWrite = 1'b0;
  logic        isUser = 1'b0;
  logic [31:0] dirBase = '0;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWData;
  logic        memAck = 1'b0;
  logic [31:0] memRData = '0;
  logic        done, fault;
  logic [1:0]  faultCode;
  logic [31:0] physAddr;

  always #10 clk = ~clk;

  pageWalker u_dut (
    .clk(clk), .rstN(rstN), .start(start), .linAddr(linAddr),
    .isWrite(isWrite), .isUser(isUser), .dirBase(dirBase),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memAck(memAck), .memRData(memRData), .done(done), .fault(fault),
    .faultCode(faultCode), .physAddr(physAddr)
  );

  // memory model: 8 KB, variable wait states, access log
  logic [31:0] mem [0:2047];
  int          lat = 0;
  int          stallCnt = 0;
  logic        clrLog = 1'b0;
  int          rdCnt = 0, wrCnt = 0;
  logic [31:0] rdLog [0:3];
  logic [31:0] wrLog [0:3];
  logic [31:0] wrDat [0:3];

  always @(posedge clk) begin
    if (clrLog) begin
      rdCnt <= 0;
      wrCnt <= 0;
    end
    if (memReq && !memAck) begin
      if (stallCnt < lat) begin
        stallCnt <= stallCnt + 1;
        memAck   <= 1'b0;
      end else begin
        stallCnt <= 0;
        memAck   <= 1'b1;
        memRData <= mem[memAddr[12:2]];
        if (memWe) begin
          mem[memAddr[12:2]] <= memWData;
          if (wrCnt < 4) begin
            wrLog[wrCnt] <= memAddr;
            wrDat[wrCnt] <= memWData;
          end
          wrCnt <= wrCnt + 1;
        end else begin
          if (rdCnt < 4) rdLog[rdCnt] <= memAddr;
          rdCnt <= rdCnt + 1;
        end
      end
    end else begin
      memAck <= 1'b0;
    end
  end

  int nChk = 0;
  int nBad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(!done && !fault && !memReq, "R9 reset flags", {29'd0, done, fault, memReq}, 32'd0);
    chk(faultCode == 2'b00, "R9 reset code", {30'd0, faultCode}, 32'd0);
    chk(physAddr == 32'd0, "R9 reset physAddr", physAddr, 32'd0);

    for (int v = 0; v < 2048; v++) begin
      logic [9:0]  dIdx, tIdx;
      logic [11:0] off;
      logic        pP, pRW, pU, tP, tRW, tU, usr, wr, pA, tA, tD, ok, np;
      logic [31:0] pdeV, pteV, pdeAd, pteAd, expPde, expPte, expPhys, la;
      logic [1:0]  expCode;
      int          expRd, expWr, wait_n;
      bit          pdeWb, pteWb;

      pP = v[0]; pRW = v[1]; pU = v[2];
      tP = v[3]; tRW = v[4]; tU = v[5];
      usr = v[6]; wr = v[7];
      pA = v[8]; tA = v[9]; tD = v[10];
      dIdx = 10'((v * 7) % 1024);
      tIdx = 10'((v * 13 + 5) % 1024);
      off  = 12'((v * 37) & 12'hFFF);
      la   = {dIdx, tIdx, off};

      pdeV = 32'h0000_1000;
      pdeV[11:9] = 3'(v + 1); pdeV[4] = v[3]; pdeV[3] = v[4];
      pdeV[0] = pP; pdeV[1] = pRW; pdeV[2] = pU; pdeV[5] = pA;
      pteV = {20'h80000 ^ 20'(v), 12'h000};
      pteV[11:9] = 3'(v + 3); pteV[4] = v[1]; pteV[3] = v[0];
      pteV[0] = tP; pteV[1] = tRW; pteV[2] = tU; pteV[5] = tA; pteV[6] = tD;

      pdeAd = {20'd0, dIdx, 2'b00};
      pteAd = 32'h1000 + {20'd0, tIdx, 2'b00};
      mem[pdeAd[12:2]] = pdeV;
      mem[pteAd[12:2]] = pteV;
      lat = v % 3;

      // expected outcome from the requirements
      np = !pP || !tP;
      ok = !np && (!usr || (pU && tU && (!wr || (pRW && tRW))));
      expCode = np ? 2'b01 : (ok ? 2'b00 : 2'b10);
      expRd = pP ? 2 : 1;
      pdeWb = ok && !pA;
      pteWb = ok && (!tA || (wr && !tD));
      expWr = int'(pdeWb) + int'(pteWb);
      expPde = pdeV | (pdeWb ? 32'h20 : 32'h0);
      expPte = pteV | (ok ? (32'h20 | (wr ? 32'h40 : 32'h0)) : 32'h0);
      expPhys = ok ? {pteV[31:12], off} : 32'h0;

      clrLog = 1'b1;
      @(negedge clk);
      clrLog = 1'b0;
      dirBase = 32'h0; linAddr = la; isWrite = wr; isUser = usr; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (v % 5 == 0) begin
        @(negedge clk);
        @(negedge clk);
        linAddr = ~la; isWrite = ~wr; start = 1'b1;  // R9: must be ignored
        @(negedge clk);
        start = 1'b0;
      end
      wait_n = 0;
      while (!done && wait_n < 200) begin
        @(negedge clk);
        wait_n++;
      end
      chk(done == 1'b1, "R3 completion seen", {31'd0, done}, 32'd1);
      chk(faultCode == expCode, np ? "R4 fault code" : (usr ? "R6 fault code" : "R5 fault code"),
          {30'd0, faultCode}, {30'd0, expCode});
      chk(fault == (expCode != 2'b00), "R4 fault flag", {31'd0, fault}, {31'd0, expCode != 2'b00});
      chk(physAddr == expPhys, "R3 physAddr", physAddr, expPhys);
      chk(rdCnt == expRd, "R4 read count", 32'(rdCnt), 32'(expRd));
      chk(rdLog[0] == pdeAd, "R1 directory address", rdLog[0], pdeAd);
      if (expRd == 2) chk(rdLog[1] == pteAd, "R2 table address", rdLog[1], pteAd);
      chk(wrCnt == expWr, "R7 write count", 32'(wrCnt), 32'(expWr));
      if (pdeWb) chk(wrLog[0] == pdeAd, "R10 first write is directory", wrLog[0], pdeAd);
      if (pteWb) chk(wrLog[expWr-1] == pteAd, "R10 table write last", wrLog[expWr-1], pteAd);
      chk(mem[pdeAd[12:2]] == expPde, "R7 final directory entry", mem[pdeAd[12:2]], expPde);
      chk(mem[pteAd[12:2]] == expPte, "R7 final table entry", mem[pteAd[12:2]], expPte);
      @(negedge clk);
      chk(done == 1'b0, "R3 done single cycle", {31'd0, done}, 32'd0);
      repeat (2) @(negedge clk);
      chk(rdCnt == expRd && !memReq, "R9 no extra walk", 32'(rdCnt), 32'(expRd));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule